// File: doc/BRIEF.md
# Masked chip-select address decoder

This block decodes bus accesses into chip selects for six external devices. Each channel holds a 16-bit base and a 16-bit mask that are compared against address bits 31 to 16. A set mask bit removes that address bit from the comparison. A clear mask bit requires the address bit to equal the base bit. Masked bits need not be adjacent, so one channel can cover several separate 64 KB-aligned windows. The region size of a channel is 2^(16 + number of set mask bits) bytes. Address bits 15 to 0 never take part in the decode.

A small register port writes and reads the channel settings. Each channel also carries an enable bit and a write-protect bit. For each request the block asserts at most one chip select, and when several channels match, the lowest-numbered one wins. A write whose winning channel is protected asserts no chip select. It raises a bus-error pulse instead, so no external cycle starts.

Top module: `csel_decoder`

## Requirements
- R1: After reset every configuration bit reads zero, and both `cs_o` and `err_o` are zero.
- R2: Channel n's base register sits at byte offset 12*n and holds the base in bits 31:16, with bits 15:0 reading zero. Its mask register sits at 12*n+4. Any other offset reads zero, and a write there changes no register.
- R3: The mask register holds the mask in bits 31:16, write protect in bit 8 and enable in bit 0. Bits 15:9 and 7:1 read zero and ignore writes.
- R4: A channel matches when, for every bit k in 31:16 whose mask bit is clear, address bit k equals base bit k. Masked bits and address bits 15:0 do not affect the match.
- R5: Base 0x0040 with mask 0x0008 selects both 0x0040_0000–0x0040_FFFF and 0x0048_0000–0x0048_FFFF, and nothing in between.
- R6: A channel whose mask has k set bits matches exactly 2^k of the 65536 values of address bits 31:16.
- R7: A channel whose enable bit is 0 never asserts its chip select, whatever its base and mask hold.
- R8: When several enabled channels match, only the lowest-numbered one asserts its chip select, so `cs_o` is one-hot or zero.
- R9: When the winning channel has write protect set, a write gives `err_o`=1 and `cs_o`=0. A read of the same address asserts that channel's chip select.
- R10: A request that matches no enabled channel gives `cs_o`=0 and `err_o`=0.
- R11: `cs_o` and `err_o` reflect the request sampled at the previous clock edge and last one cycle. They are zero after any edge where `req_valid` was low.
- R12: Channel 0 with base 0x0000 and mask 0x01FF covers 0x0000_0000–0x01FF_FFFF. Channel 1 with base 0x0200 and mask 0x00FF covers 0x0200_0000–0x02FF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 for write, 0 for read |
| cs_o | output | 6 | Chip selects, active high, one cycle after the request |
| err_o | output | 1 | Write-protect bus error, one cycle after the request |

## Verification
`cs_o` and `err_o` come from a register loaded at the edge that samples the request. The bench therefore drives each request at a falling edge and reads the result at the next falling edge, one full cycle later. At that point it also drops `req_valid`. Register reads are combinational, so read data is checked a short delay after `cfg_addr` changes. A register write is issued a whole cycle before any request that depends on it. Every result is compared against a model that the bench computes with its own OR-based match formula, over one full sweep of the upper address half and a mixed multi-channel sweep.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int unsigned FIELD_W = 16;

  typedef struct packed {
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] mask;
    logic               wprot;
    logic               enable;
  } chan_cfg_t;

  // Match rule: every unmasked upper address bit must equal the base bit.
  function automatic logic chan_hit(input chan_cfg_t c, input logic [FIELD_W-1:0] upper);
    return c.enable && (((upper ^ c.base) & ~c.mask) == '0);
  endfunction

  // Readback layout of the base register.
  function automatic logic [31:0] pack_base(input chan_cfg_t c);
    return {c.base, 16'h0000};
  endfunction

  // Readback layout of the mask register: mask high, protect bit 8, enable bit 0.
  function automatic logic [31:0] pack_mask(input chan_cfg_t c);
    return {c.mask, 7'b0, c.wprot, 7'b0, c.enable};
  endfunction

  function automatic int unsigned base_off(input int unsigned ch, input int unsigned stride);
    return ch * stride;
  endfunction

  function automatic int unsigned mask_off(input int unsigned ch, input int unsigned stride);
    return ch * stride + 4;
  endfunction

endpackage

// File: rtl/csel_chan_regs.sv
module csel_chan_regs
  import csel_pkg::*;
#(
  parameter int unsigned NCH    = 6,
  parameter int unsigned RAW    = 8,
  parameter int unsigned STRIDE = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [RAW-1:0]        cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  output chan_cfg_t [NCH-1:0]   cfg_o
);

  logic [NCH-1:0][31:0] rd_part;
  logic                 unused_wbits;

  // Reserved data bits are dropped on write.
  assign unused_wbits = ^{cfg_wdata[15:9], cfg_wdata[7:1]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [RAW-1:0] BOFF = RAW'(base_off(i, STRIDE));
    localparam logic [RAW-1:0] MOFF = RAW'(mask_off(i, STRIDE));

    chan_cfg_t cfg_q;
    logic      sel_base;
    logic      sel_mask;

    assign sel_base = (cfg_addr == BOFF);
    assign sel_mask = (cfg_addr == MOFF);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (cfg_wr) begin
        if (sel_base) cfg_q.base <= cfg_wdata[31:16];
        if (sel_mask) begin
          cfg_q.mask   <= cfg_wdata[31:16];
          cfg_q.wprot  <= cfg_wdata[8];
          cfg_q.enable <= cfg_wdata[0];
        end
      end
    end

    always_comb begin
      if (sel_base)      rd_part[i] = pack_base(cfg_q);
      else if (sel_mask) rd_part[i] = pack_mask(cfg_q);
      else               rd_part[i] = '0;
    end

    assign cfg_o[i] = cfg_q;

    // R3: reserved positions of a mask register read as zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sel_mask |-> (cfg_rdata[15:9] == '0 && cfg_rdata[7:1] == '0));

    // R2: low half of a base register reads as zero
    a_r2_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sel_base |-> (cfg_rdata[15:0] == '0));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NCH; i++) cfg_rdata |= rd_part[i];
  end

endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int unsigned NCH = 6
) (
  input  chan_cfg_t [NCH-1:0]  cfg_i,
  input  logic [FIELD_W-1:0]   upper_i,
  output logic [NCH-1:0]       hit_o,
  output logic [NCH-1:0]       wprot_o
);

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign hit_o[i]   = chan_hit(cfg_i[i], upper_i);
    assign wprot_o[i] = cfg_i[i].wprot;
  end

endmodule

// File: rtl/csel_arbiter.sv
module csel_arbiter #(
  parameter int unsigned NCH = 6
) (
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] wprot_i,
  input  logic           write_i,
  output logic [NCH-1:0] win_o,
  output logic           fault_o
);

  // Isolate the lowest set bit: lowest channel number has priority.
  assign win_o   = hit_i & (~hit_i + NCH'(1));
  assign fault_o = write_i && ((win_o & wprot_i) != '0);

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int unsigned NCH    = 6,
  parameter int unsigned RAW    = 8,
  parameter int unsigned STRIDE = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [RAW-1:0]  cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            req_valid,
  input  logic [31:0]     req_addr,
  input  logic            req_write,
  output logic [NCH-1:0]  cs_o,
  output logic            err_o
);

  chan_cfg_t [NCH-1:0] chan_cfg;
  logic [NCH-1:0]      chan_hit_w;
  logic [NCH-1:0]      chan_wp_w;
  logic [NCH-1:0]      chan_en_w;
  logic [NCH-1:0]      win_w;
  logic                fault_w;
  logic [NCH-1:0]      cs_q;
  logic                err_q;
  logic                unused_low;

  assign unused_low = ^req_addr[15:0];

  csel_chan_regs #(.NCH(NCH), .RAW(RAW), .STRIDE(STRIDE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_o     (chan_cfg)
  );

  csel_match #(.NCH(NCH)) u_match (
    .cfg_i   (chan_cfg),
    .upper_i (req_addr[31:16]),
    .hit_o   (chan_hit_w),
    .wprot_o (chan_wp_w)
  );

  csel_arbiter #(.NCH(NCH)) u_arb (
    .hit_i   (chan_hit_w),
    .wprot_i (chan_wp_w),
    .write_i (req_write),
    .win_o   (win_w),
    .fault_o (fault_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_en
    assign chan_en_w[i] = chan_cfg[i].enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= '0;
      err_q <= 1'b0;
    end else if (req_valid) begin
      cs_q  <= fault_w ? '0 : win_w;
      err_q <= fault_w;
    end else begin
      cs_q  <= '0;
      err_q <= 1'b0;
    end
  end

  assign cs_o  = cs_q;
  assign err_o = err_q;

  // R8: never more than one chip select
  a_r8_onehot_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_q));

  // R9: a fault never comes with a chip select
  a_r9_err_excludes_cs: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (cs_q == '0));

  // R9: faults come only from writes
  a_r9_err_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(req_write));

  // R11: outputs only follow a sampled request
  a_r11_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_q != '0) || err_q) |-> $past(req_valid));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R7: a disabled channel is never selected
    a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q[i] |-> $past(chan_en_w[i]));

    // R9: a protected channel is never selected for a write
    a_r9_protected_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q[i] && $past(req_write)) |-> !$past(chan_wp_w[i]));
  end

endmodule

// File: tb/sim_csel_decoder.sv
module sim_csel_decoder;

  localparam int CLK_NS = 10;
  localparam int NCH    = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [NCH-1:0] cs_o;
  logic        err_o;

  int n_checks = 0;
  int n_errors = 0;

  logic [15:0] sh_base [NCH];
  logic [15:0] sh_mask [NCH];
  logic        sh_wp   [NCH];
  logic        sh_en   [NCH];

  always #(CLK_NS/2) clk = ~clk;

  csel_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .cs_o(cs_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected {err, cs}: bench form of the match is (a|m)==(b|m).
  function automatic logic [NCH:0] model(input logic [31:0] a, input logic wr);
    logic [15:0] up;
    up = a[31:16];
    for (int i = 0; i < NCH; i++) begin
      if (sh_en[i] && ((up | sh_mask[i]) == (sh_base[i] | sh_mask[i]))) begin
        if (wr && sh_wp[i]) return {1'b1, {NCH{1'b0}}};
        return {1'b0, NCH'(1) << i};
      end
    end
    return '0;
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic set_chan(input int n, input logic [15:0] b, input logic [15:0] m,
                          input logic wp, input logic en);
    reg_write(8'(12*n), {b, 16'h0});
    reg_write(8'(12*n + 4), {m, 7'b0, wp, 7'b0, en});
    sh_base[n] = b; sh_mask[n] = m; sh_wp[n] = wp; sh_en[n] = en;
  endtask

  // Request driven at a falling edge, result read one cycle later.
  task automatic access(input logic [31:0] a, input logic wr, output logic [NCH:0] got);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(negedge clk);
    got = {err_o, cs_o};
    req_valid = 1'b0;
  endtask

  task automatic expect_access(input string req, input logic [31:0] a, input logic wr,
                               input logic [NCH:0] exp);
    logic [NCH:0] got;
    access(a, wr, got);
    check(req, 32'(got), 32'(exp));
    check({req, " model"}, 32'(exp), 32'(model(a, wr)));
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [NCH:0] got;
    logic [31:0] lf;
    int hits;

    for (int i = 0; i < NCH; i++) begin
      sh_base[i] = '0; sh_mask[i] = '0; sh_wp[i] = 1'b0; sh_en[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 cs", 32'(cs_o), 32'h0);
    check("R1 err", 32'(err_o), 32'h0);
    for (int a = 0; a < 8'h48; a += 4) begin
      reg_read(8'(a), rd);
      check("R1 reg zero", rd, 32'h0);
    end

    // R2/R3: field layout, reserved bits, holes
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, rd);
    check("R2 base readback", rd, 32'hFFFF_0000);
    reg_write(8'h04, 32'hFFFF_FFFF);
    reg_read(8'h04, rd);
    check("R3 mask readback", rd, 32'hFFFF_0101);
    reg_write(8'h08, 32'hFFFF_FFFF);
    reg_read(8'h08, rd);
    check("R2 hole reads zero", rd, 32'h0);
    reg_read(8'h0C, rd);
    check("R2 hole write ignored ch1 base", rd, 32'h0);
    reg_read(8'h10, rd);
    check("R2 hole write ignored ch1 mask", rd, 32'h0);
    reg_write(8'h40, 32'hA5A5_0100);
    reg_read(8'h40, rd);
    check("R2 ch5 mask offset 0x40", rd, 32'hA5A5_0100);
    reg_write(8'h3C, 32'h1234_5678);
    reg_read(8'h3C, rd);
    check("R2 ch5 base offset 0x3C", rd, 32'h1234_0000);
    set_chan(0, 16'h0, 16'h0, 1'b0, 1'b0);
    set_chan(5, 16'h0, 16'h0, 1'b0, 1'b0);

    // R5: split windows
    set_chan(0, 16'h0040, 16'h0008, 1'b0, 1'b1);
    expect_access("R5 low window start", 32'h0040_0000, 1'b0, 7'h01);
    expect_access("R5 low window end", 32'h0040_FFFF, 1'b0, 7'h01);
    expect_access("R5 high window", 32'h0048_1234, 1'b1, 7'h01);
    expect_access("R5 gap", 32'h0044_0000, 1'b0, 7'h00);
    expect_access("R10 no match", 32'h0050_0000, 1'b1, 7'h00);

    // R11: idle cycle gives zero outputs
    @(negedge clk);
    check("R11 idle cs", 32'(cs_o), 32'h0);
    check("R11 idle err", 32'(err_o), 32'h0);

    // R4/R6: full sweep of the upper address half, 4 mask bits set
    set_chan(0, 16'h1234, 16'h0A50, 1'b0, 1'b1);
    hits = 0;
    for (int u = 0; u < 65536; u++) begin
      access({16'(u), 16'(u * 7)}, u[0], got);
      if (got[0]) hits++;
      if (got !== model({16'(u), 16'h0}, u[0])) begin
        check("R4 sweep", 32'(got), 32'(model({16'(u), 16'h0}, u[0])));
      end
    end
    n_checks++;
    check("R6 region count", 32'(hits), 32'd16);

    // R12: adjacent regions
    set_chan(0, 16'h0000, 16'h01FF, 1'b0, 1'b1);
    set_chan(1, 16'h0200, 16'h00FF, 1'b0, 1'b1);
    expect_access("R12 ch0 start", 32'h0000_0000, 1'b0, 7'h01);
    expect_access("R12 ch0 end", 32'h01FF_FFFF, 1'b0, 7'h01);
    expect_access("R12 ch1 start", 32'h0200_0000, 1'b0, 7'h02);
    expect_access("R12 ch1 end", 32'h02FF_FFFF, 1'b1, 7'h02);
    expect_access("R12 beyond", 32'h0300_0000, 1'b0, 7'h00);

    // R8: priority with catch-all channel 2
    set_chan(2, 16'h0000, 16'hFFFF, 1'b0, 1'b1);
    expect_access("R8 lowest wins", 32'h0100_0000, 1'b0, 7'h01);
    expect_access("R8 ch1 over ch2", 32'h0280_0000, 1'b0, 7'h02);
    expect_access("R8 only ch2", 32'h0500_0000, 1'b0, 7'h04);

    // R7: enable bit
    set_chan(0, 16'h0000, 16'h01FF, 1'b0, 1'b0);
    expect_access("R7 ch0 disabled", 32'h0100_0000, 1'b0, 7'h04);
    set_chan(1, 16'h0200, 16'h00FF, 1'b0, 1'b0);
    set_chan(2, 16'h0000, 16'hFFFF, 1'b0, 1'b0);
    expect_access("R7 all disabled", 32'h0100_0000, 1'b0, 7'h00);

    // R9: write protect
    set_chan(3, 16'h8000, 16'h0000, 1'b1, 1'b1);
    expect_access("R9 protected read", 32'h8000_0010, 1'b0, 7'h08);
    expect_access("R9 protected write", 32'h8000_0010, 1'b1, 7'h40);
    @(negedge clk);
    check("R11 err one cycle", 32'(err_o), 32'h0);
    set_chan(1, 16'h8000, 16'h0000, 1'b0, 1'b1);
    expect_access("R9 lower unprotected wins", 32'h8000_0010, 1'b1, 7'h02);
    set_chan(1, 16'h8000, 16'h0000, 1'b0, 1'b0);

    // R4/R8/R9: mixed multi-channel sweep
    lf = 32'hACE1_2B5D;
    for (int i = 0; i < NCH; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      set_chan(i, lf[31:16], lf[15:0] & {lf[7:0], lf[15:8]}, lf[3], i != 4);
    end
    for (int k = 0; k < 4096; k++) begin
      logic [15:0] up;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      if (lf[0]) up = sh_base[k % NCH] ^ (lf[31:16] & sh_mask[k % NCH]);
      else       up = lf[31:16];
      access({up, lf[15:0]}, lf[1], got);
      if (got !== model({up, lf[15:0]}, lf[1]))
        check("R8 mixed sweep", 32'(got), 32'(model({up, lf[15:0]}, lf[1])));
    end
    n_checks++;

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule